// File: doc/BRIEF.md
# End-Around-Carry Checksum Accumulator

This block folds a stream of 32-bit words into a running sum using one's-complement addition. When the binary sum of the stored value and the incoming word does not fit in 32 bits, the carry that drops off the top is added back at the least significant bit. Each word with its valid strobe high is taken in on the next rising clock edge. The accumulator accepts one word per clock with no stall. A synchronous clear returns the sum to zero. Checksum engines and pseudorandom generators that call for this wrap-around arithmetic use the block as their adder core.

The stored sum may hold the all-ones pattern. This is a legal state, and later additions treat it the same way a true modulo-(2^32-1) sum treats zero. A second output shows the same value normalised: all ones is shown as zero, which gives a proper residue in the range 0 to 2^32-2. The register itself is never rewritten by this normalisation.

The wrapped carry is not routed from the adder's carry-out back to its own carry-in. The block instead adds two double-width operands, each made of the operand placed twice side by side. The upper half of that sum is already the wrapped result, so the logic has no combinational loop and static timing analysis covers it. A parameter selects a strict variant that adds a bottom +1. That variant decides the wrap from the carry of X+Y+1 and so never produces all ones.

Top module: `wrapsum_accum`

## Requirements
- R1: While reset is asserted, and once it is released, both outputs read 0 until the first clear or valid word is taken.
- R2: When clear is high on a rising edge, the sum becomes 0 on that edge. Clear takes priority over a valid word in the same cycle.
- R3: When clear and valid are both low on a rising edge, the sum keeps its value.
- R4: When valid is high and clear is low, the new sum is S+D if S+D < 2^32. Otherwise it is S+D-2^32+1, where S is the stored sum and D is the data word.
- R5: All ones (0xFFFFFFFF) is a legal stored sum. Operands that add to exactly 2^32-1 leave 0xFFFFFFFF. Adding 0 to 0xFFFFFFFF keeps 0xFFFFFFFF.
- R6: The normalised output equals the sum output, except that a sum of 0xFFFFFFFF is shown as 0. The normalised output is never 0xFFFFFFFF.
- R7: A valid word on every clock is accumulated with no gaps. Each result appears on the sum output right after the edge that takes its word in.
- R8: Wrap cases give these results: 0xFFFFFFFF + 0x00000001 gives 0x00000001, and 0xFFFFFFFF + 0xFFFFFFFF gives 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr_i | input | 1 | Synchronous clear of the running sum |
| vld_i | input | 1 | Data word valid strobe |
| data_i | input | 32 | Word to fold into the sum |
| sum_o | output | 32 | Running end-around-carry sum, may be all ones |
| sum_norm_o | output | 32 | Running sum with all ones shown as zero |

## Verification
Every step feeds the stored sum back into the adder. A single wrong bit in the register therefore shows on sum_o right after the edge that wrote it. It then carries into every later result until the next clear. A carry that is wrapped wrongly, dropped, or added twice shows up only on sums at or above 2^32-1. Those cases are driven on purpose, and both outputs are compared after every edge. A normaliser fault shows on the same edge, and only when the sum is all ones.

// File: rtl/wrapsum_pkg.sv
package wrapsum_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned SYNC_STAGES = 2;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/wrapsum_rst_sync.sv
module wrapsum_rst_sync #(
  parameter int unsigned STAGES = wrapsum_pkg::SYNC_STAGES
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/wrapsum_adder.sv
// Loop-free wrapped adder: operands are doubled side by side so the carry of
// the low half lands in the high half as its carry-in.
module wrapsum_adder #(
  parameter int unsigned W      = wrapsum_pkg::WORD_W,
  parameter bit          STRICT = 1'b0
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  localparam int unsigned DW = 2 * W;

  logic [DW-1:0] a_dbl;
  logic [DW-1:0] b_dbl;
  logic [DW-1:0] dbl_sum;

  assign a_dbl = {a_i, a_i};
  assign b_dbl = {b_i, b_i};

  generate
    if (STRICT) begin : g_strict
      // carry of a+b+1 decides the wrap: all ones folds to zero
      assign dbl_sum = a_dbl + b_dbl + DW'(1);
    end else begin : g_eac
      // carry of a+b decides the wrap: all ones stays legal
      assign dbl_sum = a_dbl + b_dbl;
    end
  endgenerate

  assign y_o = dbl_sum[DW-1:W];
endmodule

// File: rtl/wrapsum_norm.sv
module wrapsum_norm #(
  parameter int unsigned W = wrapsum_pkg::WORD_W
) (
  input  logic [W-1:0] val_i,
  output logic [W-1:0] norm_o
);
  logic is_ones;

  always_comb begin
    is_ones = &val_i;
    norm_o  = is_ones ? '0 : val_i;
  end
endmodule

// File: rtl/wrapsum_accum.sv
module wrapsum_accum #(
  parameter int unsigned W      = wrapsum_pkg::WORD_W,
  parameter bit          STRICT = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         vld_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] sum_o,
  output logic [W-1:0] sum_norm_o
);
  logic         rst_sync_n;
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_d;
  logic         acc_en;
  logic [W-1:0] add_y;

  wrapsum_rst_sync u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  wrapsum_adder #(.W(W), .STRICT(STRICT)) u_adder (
    .a_i (acc_q),
    .b_i (data_i),
    .y_o (add_y)
  );

  // next-state logic
  always_comb begin
    acc_en = clr_i | vld_i;
    acc_d  = acc_q;
    if (clr_i) begin
      acc_d = '0;
    end else if (vld_i) begin
      acc_d = add_y;
    end
  end

  // state register
  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  wrapsum_norm #(.W(W)) u_norm (
    .val_i  (acc_q),
    .norm_o (sum_norm_o)
  );

  assign sum_o = acc_q;
endmodule

// File: rtl/wrapsum_accum_chk.sv
module wrapsum_accum_chk #(
  parameter int unsigned W      = wrapsum_pkg::WORD_W,
  parameter bit          STRICT = 1'b0
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_i,
  input logic         vld_i,
  input logic [W-1:0] data_i,
  input logic [W-1:0] sum_o,
  input logic [W-1:0] sum_norm_o
);
  function automatic logic [W-1:0] fold_ref(input logic [W-1:0] s, input logic [W-1:0] d);
    logic [W:0] wide;
    wide = {1'b0, s} + {1'b0, d};
    return wide[W-1:0] + {{(W-1){1'b0}}, wide[W]};
  endfunction

  // R2: clear wins and zeroes the sum
  p_clear_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (sum_o == '0));

  // R3: idle cycle holds the sum
  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !vld_i) |=> $stable(sum_o));

  // R4: valid word folds with end-around carry
  p_fold_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i && !STRICT) |=> (sum_o == fold_ref($past(sum_o), $past(data_i))));

  // R5: adding zero keeps any value, all ones included
  p_zero_keeps_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && !clr_i && data_i == '0 && !STRICT) |=> $stable(sum_o));

  // R6: normalised output never all ones and only differs on all ones
  p_norm_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(&sum_norm_o));
  p_norm_diff_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum_norm_o != sum_o) |-> ((&sum_o) && sum_norm_o == '0));
endmodule

bind wrapsum_accum wrapsum_accum_chk #(.W(W), .STRICT(STRICT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .vld_i      (vld_i),
  .data_i     (data_i),
  .sum_o      (sum_o),
  .sum_norm_o (sum_norm_o)
);

// File: tb/wrapsum_accum_tb.sv
module wrapsum_accum_tb_top;
  localparam int unsigned W = 32;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WATCHDOG_CYCLES = 200000;

  logic         clk_i = 1'b0;
  logic         rst_ni;
  logic         clr_i;
  logic         vld_i;
  logic [W-1:0] data_i;
  logic [W-1:0] sum_o;
  logic [W-1:0] sum_norm_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [W-1:0] model;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  wrapsum_accum dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr_i),
    .vld_i      (vld_i),
    .data_i     (data_i),
    .sum_o      (sum_o),
    .sum_norm_o (sum_norm_o)
  );

  // 64-bit reference: add, then fold the upper bits back in
  function automatic logic [W-1:0] ref_fold(input logic [W-1:0] s, input logic [W-1:0] d);
    logic [63:0] wide;
    wide = {32'd0, s} + {32'd0, d};
    return wide[31:0] + wide[63:32];
  endfunction

  function automatic logic [W-1:0] ref_norm(input logic [W-1:0] s);
    return (s == 32'hFFFF_FFFF) ? 32'd0 : s;
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // drive one cycle, update model, check right after the edge
  task automatic step(input bit c, input bit v, input logic [W-1:0] d, input string req);
    @(negedge clk_i);
    clr_i  = c;
    vld_i  = v;
    data_i = d;
    if (c) model = '0;
    else if (v) model = ref_fold(model, d);
    @(posedge clk_i);
    #1;
    check(req, sum_o, model);
    check("R6", sum_norm_o, ref_norm(model));
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    clr_i  = 1'b0;
    vld_i  = 1'b0;
    data_i = '0;
    model  = '0;
    repeat (3) @(posedge clk_i);
    #1;
    check("R1", sum_o, 32'd0);
    check("R1", sum_norm_o, 32'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);
    #1;
    check("R1", sum_o, 32'd0);

    // R4 plain add, R3 hold
    step(1'b0, 1'b1, 32'h0000_1234, "R4");
    step(1'b0, 1'b0, 32'hDEAD_BEEF, "R3");
    step(1'b0, 1'b1, 32'h1000_0000, "R4");
    // R2 clear with valid: clear wins
    step(1'b1, 1'b1, 32'h5555_5555, "R2");
    // R5 exactly 2^32-1
    step(1'b0, 1'b1, 32'h8000_0000, "R4");
    step(1'b0, 1'b1, 32'h7FFF_FFFF, "R5");
    check("R5", sum_o, 32'hFFFF_FFFF);
    step(1'b0, 1'b1, 32'h0000_0000, "R5");
    check("R5", sum_o, 32'hFFFF_FFFF);
    check("R6", sum_norm_o, 32'd0);
    // R8 all ones + 1
    step(1'b0, 1'b1, 32'h0000_0001, "R8");
    check("R8", sum_o, 32'h0000_0001);
    // R8 all ones + all ones
    step(1'b1, 1'b0, 32'd0, "R2");
    step(1'b0, 1'b1, 32'hFFFF_FFFF, "R4");
    step(1'b0, 1'b1, 32'hFFFF_FFFF, "R8");
    check("R8", sum_o, 32'hFFFF_FFFF);
    step(1'b0, 1'b0, 32'h0000_0001, "R3");
    // R7 back-to-back burst of large words
    for (int i = 0; i < 16; i++) begin
      step(1'b0, 1'b1, 32'hF000_0000 | 32'(i * 32'h0101_0101), "R7");
    end

    // constrained random mix
    void'($urandom(32'd20151219));
    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] d;
      int sel;
      bit c;
      bit v;
      sel = $urandom_range(0, 9);
      c = ($urandom_range(0, 31) == 0);
      v = ($urandom_range(0, 3) != 0);
      case (sel)
        0:       d = ~model;
        1:       d = 32'hFFFF_FFFF;
        2:       d = 32'd0;
        3:       d = ~model + 32'd1;
        default: d = $urandom;
      endcase
      step(c, v, d, c ? "R2" : (v ? "R4" : "R3"));
    end

    finish_run();
  end
endmodule